// File: doc/BRIEF.md
# Indexed-Access System Interrupt Controller

This block gathers a parameterised set of system interrupt lines (64 by default) and merges them into a single interrupt request for a processor. Each line runs through a two-flop synchroniser and then a detector. Two configuration bits per line choose what the detector looks for: a rising edge, a falling edge, a high level or a low level. A detected event sets a latched status bit. A line can raise the request only when its enable bit is also set.

Software reaches the block through a simple 32-bit register bus. The write strobe is sampled on the clock edge, and read data is combinational from the address. There are two ways to change status and enable bits:

- **By index:** write one interrupt number to a dedicated register to clear that line's status, enable it, or disable it.
- **By bitmap:** write a 32-bit word to clear any group of bits at once.

Every line carries a 3-bit channel number. A prioritised index register reports the pending, enabled line with the lowest channel, and sets a "none" flag when nothing is pending. The request output is gated by a global enable and by a host enable.

Top module: `sysint_ctrl`

## Requirements
- R1: After reset, `irq_out` is low, the prioritised index register (0x80) reads 0x80000000, and the global enable (0x10), status words (0x280+4n) and enable words (0x380+4n) read zero.
- R2: Detection is set per line by one polarity bit (word 0xD00+4n) and one type bit (word 0xD80+4n), at bit position index mod 32. The four encodings are:
  - type 1, polarity 1: rising edge
  - type 1, polarity 0: falling edge
  - type 0, polarity 1: high level
  - type 0, polarity 0: low level
  
  Both bits reset to 1.
- R3: An edge-mode status bit stays set after the input returns to idle, until software clears it. A level-mode status bit is set again on every cycle its level is active, so a clear has no lasting effect while the level holds.
- R4: Writing an interrupt number to 0x24 clears that line's status bit and no other. A value of NUM_IRQ or above changes nothing.
- R5: Writing an interrupt number to 0x28 enables that line, and writing it to 0x2C disables it. A value of NUM_IRQ or above changes nothing.
- R6: A write to 0x280+4n clears the status bits of lines 32n..32n+31 where the written bit is 1. A write to 0x380+4n does the same for the enable bits. Bits written as 0 are unchanged. Reads of these words return the current status and enable bits.
- R7: Word 0x400+4n holds the channels of lines 4n..4n+3. Line 4n+k uses bits 8k+2..8k and the other bits read zero. Channels reset to 0.
- R8: The prioritised index register 0x80 reports the winning line in bits 9:0, with bit 31 clear. The winner is the pending, enabled line with the lowest channel number, and the lowest index breaks a tie. When no line is pending and enabled, the register reads 0x80000000.
- R9: `irq_out` is high exactly when all three of these hold:
  - bit 0 of the global enable (0x10) is 1;
  - the host enable is 1 (writing 1 to 0x34 sets it, writing 1 to 0x38 clears it, and it is visible as bit 1 of 0x1500);
  - some enabled line has its status set.
- R10: A change on an input line reaches its status bit, and `irq_out`, on the third rising clock edge after the change.
- R11: The control words 0x04 and 0x0C always read zero, and writes to them have no effect (normal mode only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_IRQ | Asynchronous system interrupt lines |
| bus_we | input | 1 | Register write strobe, sampled on the clock edge |
| bus_addr | input | 13 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_out | output | 1 | Interrupt request to the host |

## Verification
A table drives one line in each detection mode, in words 0 and 1, with input patterns that should and should not latch status:
- rising 0→1 against 1→0;
- falling 1→0 against 0→1;
- levels held active against held idle.

This separates a swapped polarity bit from a swapped type bit, and shows that edges are not treated as levels. Directed steps then cover the following:
- the three-edge latency;
- index and bitmap clears next to untouched neighbours;
- out-of-range indices;
- each gate on the request;
- a channel-ordered winner against an index-ordered tie;
- a level that keeps re-latching after a clear.

// File: rtl/sic_pkg.sv
// Package: shared constants and helpers for the system interrupt controller.
// Assumes a 13-bit byte address and a 32-bit data bus.
package sic_pkg;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 32;
    localparam int PIDX_W = 10;

    localparam logic [ADDR_W-1:0] A_CTRL      = 13'h0004;
    localparam logic [ADDR_W-1:0] A_HCTRL     = 13'h000C;
    localparam logic [ADDR_W-1:0] A_GLB       = 13'h0010;
    localparam logic [ADDR_W-1:0] A_STCLR_IX  = 13'h0024;
    localparam logic [ADDR_W-1:0] A_ENSET_IX  = 13'h0028;
    localparam logic [ADDR_W-1:0] A_ENCLR_IX  = 13'h002C;
    localparam logic [ADDR_W-1:0] A_HSET_IX   = 13'h0034;
    localparam logic [ADDR_W-1:0] A_HCLR_IX   = 13'h0038;
    localparam logic [ADDR_W-1:0] A_PRIO      = 13'h0080;
    localparam logic [ADDR_W-1:0] B_STAT      = 13'h0280;
    localparam logic [ADDR_W-1:0] B_ENBL      = 13'h0380;
    localparam logic [ADDR_W-1:0] B_CMAP      = 13'h0400;
    localparam logic [ADDR_W-1:0] B_POL       = 13'h0D00;
    localparam logic [ADDR_W-1:0] B_TYP       = 13'h0D80;
    localparam logic [ADDR_W-1:0] A_HOSTEN    = 13'h1500;

    // True when the detector sees its configured condition.
    function automatic logic det_hit(logic pol, logic typ, logic cur, logic prev);
        logic r;
        if (typ) r = pol ? (cur & ~prev) : (~cur & prev);
        else     r = pol ? cur : ~cur;
        return r;
    endfunction
endpackage

// File: rtl/sic_detect.sv
// Per-line synchroniser, edge/level detector and latched status bits.
// Assumes irq_i is asynchronous; status set wins over a clear in the same cycle.
module sic_detect #(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] pol_i,
    input  logic [NUM_IRQ-1:0] typ_i,
    input  logic [NUM_IRQ-1:0] clr_i,
    output logic [NUM_IRQ-1:0] stat_o
);
    logic [NUM_IRQ-1:0] sync1_q, sync2_q, prev_q, evt, stat_q;

    // Two-flop synchroniser followed by the previous-sample flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= irq_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_det
        // Detect the configured condition for this line.
        always_comb evt[g] = sic_pkg::det_hit(pol_i[g], typ_i[g], sync2_q[g], prev_q[g]);
    end

    // Latch events; software clears drop bits with no new event.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | evt;
    end

    assign stat_o = stat_q;

    assert_set_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));
    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & $past(clr_i & ~evt)) == '0));
endmodule

// File: rtl/sic_arbiter.sv
// Picks the pending line with the lowest channel, lowest index on ties.
// Assumes channels arrive packed CHAN_W bits per line.
module sic_arbiter #(
    parameter int NUM_IRQ = 64,
    parameter int CHAN_W  = 3,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ*CHAN_W-1:0] chan_i,
    output logic                      valid_o,
    output logic [IDX_W-1:0]          win_o
);
    logic [CHAN_W-1:0] best_ch;

    // Linear scan; strict compare keeps the lowest index on equal channels.
    always_comb begin
        valid_o = 1'b0;
        win_o   = '0;
        best_ch = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend_i[i] && (!valid_o || chan_i[i*CHAN_W +: CHAN_W] < best_ch)) begin
                valid_o = 1'b1;
                best_ch = chan_i[i*CHAN_W +: CHAN_W];
                win_o   = IDX_W'(i);
            end
        end
    end

    assert_win_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pend_i[win_o]);
    assert_none_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (pend_i == '0));
endmodule

// File: rtl/sysint_ctrl.sv
// Top: register file, index/bitmap decode and the IRQ output.
// Assumes NUM_IRQ <= 1024 and a single-cycle write strobe per access.
module sysint_ctrl #(
    parameter int NUM_IRQ = 64,
    parameter int CHAN_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               bus_we,
    input  logic [12:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out
);
    import sic_pkg::*;
    localparam int NWORD = (NUM_IRQ + 31) / 32;
    localparam int NMAP  = (NUM_IRQ + 3) / 4;
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0]        en_q, pol_q, typ_q, stat, stat_clr;
    logic [NUM_IRQ*CHAN_W-1:0] chan_q;
    logic                      glb_q, host_q, arb_valid;
    logic [IDX_W-1:0]          arb_win;
    logic [10:0]               wa;
    logic [10:0]               off_stat, off_en, off_map, off_pol, off_typ;
    logic                      in_stat, in_en, in_map, in_pol, in_typ;

    // Region decode: word offsets and range hits.
    always_comb begin
        wa       = bus_addr[12:2];
        off_stat = wa - B_STAT[12:2];
        off_en   = wa - B_ENBL[12:2];
        off_map  = wa - B_CMAP[12:2];
        off_pol  = wa - B_POL[12:2];
        off_typ  = wa - B_TYP[12:2];
        in_stat  = bus_addr >= B_STAT && int'(bus_addr) < int'(B_STAT) + 4*NWORD;
        in_en    = bus_addr >= B_ENBL && int'(bus_addr) < int'(B_ENBL) + 4*NWORD;
        in_map   = bus_addr >= B_CMAP && int'(bus_addr) < int'(B_CMAP) + 4*NMAP;
        in_pol   = bus_addr >= B_POL  && int'(bus_addr) < int'(B_POL)  + 4*NWORD;
        in_typ   = bus_addr >= B_TYP  && int'(bus_addr) < int'(B_TYP)  + 4*NWORD;
    end

    // Status clear vector from the index and bitmap writes.
    always_comb begin
        stat_clr = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (bus_we && bus_addr == A_STCLR_IX && bus_wdata == 32'(i)) stat_clr[i] = 1'b1;
            if (bus_we && in_stat && off_stat == 11'(i / 32) && bus_wdata[i % 32]) stat_clr[i] = 1'b1;
        end
    end

    // Enable bits: index set, index clear, bitmap clear.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else if (bus_we) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (bus_addr == A_ENSET_IX && bus_wdata == 32'(i)) en_q[i] <= 1'b1;
                else if (bus_addr == A_ENCLR_IX && bus_wdata == 32'(i)) en_q[i] <= 1'b0;
                else if (in_en && off_en == 11'(i / 32) && bus_wdata[i % 32]) en_q[i] <= 1'b0;
            end
        end
    end

    // Detection mode words and the channel map.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '1;
            typ_q  <= '1;
            chan_q <= '0;
        end else if (bus_we) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (in_pol && off_pol == 11'(i / 32)) pol_q[i] <= bus_wdata[i % 32];
                if (in_typ && off_typ == 11'(i / 32)) typ_q[i] <= bus_wdata[i % 32];
                if (in_map && off_map == 11'(i / 4))
                    chan_q[i*CHAN_W +: CHAN_W] <= bus_wdata[(i % 4)*8 +: CHAN_W];
            end
        end
    end

    // Global enable and host enable for the IRQ output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q  <= 1'b0;
            host_q <= 1'b0;
        end else if (bus_we) begin
            if (bus_addr == A_GLB) glb_q <= bus_wdata[0];
            if (bus_addr == A_HSET_IX && bus_wdata == 32'd1) host_q <= 1'b1;
            if (bus_addr == A_HCLR_IX && bus_wdata == 32'd1) host_q <= 1'b0;
            if (bus_addr == A_HOSTEN) host_q <= bus_wdata[1];
        end
    end

    sic_detect #(.NUM_IRQ(NUM_IRQ)) u_detect (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_in), .pol_i(pol_q),
        .typ_i(typ_q), .clr_i(stat_clr), .stat_o(stat)
    );

    sic_arbiter #(.NUM_IRQ(NUM_IRQ), .CHAN_W(CHAN_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend_i(stat & en_q), .chan_i(chan_q),
        .valid_o(arb_valid), .win_o(arb_win)
    );

    // Combined request to the host.
    always_comb irq_out = glb_q && host_q && arb_valid;

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_GLB)    bus_rdata[0] = glb_q;
        if (bus_addr == A_HOSTEN) bus_rdata[1] = host_q;
        if (bus_addr == A_PRIO)
            bus_rdata = {~arb_valid, 21'd0, PIDX_W'(arb_win)};
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (in_stat && off_stat == 11'(i / 32)) bus_rdata[i % 32] = stat[i];
            if (in_en   && off_en   == 11'(i / 32)) bus_rdata[i % 32] = en_q[i];
            if (in_pol  && off_pol  == 11'(i / 32)) bus_rdata[i % 32] = pol_q[i];
            if (in_typ  && off_typ  == 11'(i / 32)) bus_rdata[i % 32] = typ_q[i];
            if (in_map  && off_map  == 11'(i / 4))
                bus_rdata[(i % 4)*8 +: CHAN_W] = chan_q[i*CHAN_W +: CHAN_W];
        end
    end

    assert_irq_has_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (arb_valid && stat[arb_win] && en_q[arb_win]));
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_q || !host_q) |-> !irq_out);
endmodule

// File: tb/sysint_ctrl_tb_top.sv
module sysint_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic        bus_we = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] v;

    // Vector: [12:5] line, [4] polarity, [3] type, [2] before, [1] after, [0] expected.
    localparam logic [12:0] VEC [0:7] = '{
        {8'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {8'd33, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'd63, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'd20, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'd40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'd7,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd50, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'd12, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    sysint_ctrl #(.NUM_IRQ(N), .CHAN_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(pins), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int i);
        @(negedge clk); pins[i] = 1'b1;
        idle(2); pins[i] = 1'b0;
        idle(5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_run++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        #1 chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
        rd(13'h080, v); chk("R1 prio", v, 32'h8000_0000);
        rd(13'h010, v); chk("R1 global", v, 32'd0);
        rd(13'h280, v); chk("R1 status", v, 32'd0);
        rd(13'h384, v); chk("R1 enable", v, 32'd0);
        // R11 control words
        wr(13'h004, 32'hFFFF_FFFF); rd(13'h004, v); chk("R11 ctrl", v, 32'd0);
        wr(13'h00C, 32'hFFFF_FFFF); rd(13'h00C, v); chk("R11 hctrl", v, 32'd0);

        // R2/R3 detection table
        for (int k = 0; k < 8; k++) begin
            int idx;
            logic [12:0] e;
            e = VEC[k];
            idx = int'(e[12:5]);
            wr(13'hD00 + 13'(4*(idx/32)), {32{e[4]}});
            wr(13'hD80 + 13'(4*(idx/32)), {32{e[3]}});
            @(negedge clk); pins[idx] = e[2];
            idle(5);
            wr(13'h024, 32'(idx));
            idle(2);
            pins[idx] = e[1];
            idle(5);
            rd(13'h280 + 13'(4*(idx/32)), v);
            chk($sformatf("R2 R3 vector %0d line %0d", k, idx), {31'd0, v[idx%32]}, {31'd0, e[0]});
            pins[idx] = 1'b0;
        end
        pins = '0;
        wr(13'hD00, '1); wr(13'hD04, '1); wr(13'hD80, '1); wr(13'hD84, '1);
        idle(5);
        wr(13'h280, '1); wr(13'h284, '1);
        rd(13'h280, v); chk("R6 bitmap clear w0", v, 32'd0);
        rd(13'h284, v); chk("R6 bitmap clear w1", v, 32'd0);

        // R10 latency and R9 enable path
        wr(13'h010, 32'd1); wr(13'h034, 32'd1); wr(13'h028, 32'd2);
        @(negedge clk); pins[2] = 1'b1;
        @(posedge clk); @(posedge clk); #1 chk("R10 not yet", {31'd0, irq_out}, 32'd0);
        @(posedge clk); #1 chk("R10 third edge", {31'd0, irq_out}, 32'd1);
        rd(13'h080, v); chk("R8 single winner", v, 32'd2);
        @(negedge clk); pins[2] = 1'b0;
        idle(5);
        rd(13'h280, v); chk("R3 edge stays latched", v, 32'h4);

        // R4 index clear
        pulse(9); pulse(35);
        rd(13'h280, v); chk("R4 pre w0", v, 32'h204);
        wr(13'h024, 32'd9);
        rd(13'h280, v); chk("R4 clear one", v, 32'h4);
        rd(13'h284, v); chk("R4 neighbour word", v, 32'h8);
        wr(13'h024, 32'd64);
        rd(13'h280, v); chk("R4 out of range w0", v, 32'h4);
        rd(13'h284, v); chk("R4 out of range w1", v, 32'h8);

        // R6 bitmap status clear
        wr(13'h284, 32'h8); rd(13'h284, v); chk("R6 ones clear", v, 32'd0);
        wr(13'h280, 32'h0); rd(13'h280, v); chk("R6 zeros keep", v, 32'h4);

        // R9 gating
        wr(13'h038, 32'd1); #1 chk("R9 host off", {31'd0, irq_out}, 32'd0);
        rd(13'h1500, v); chk("R9 host word off", v, 32'd0);
        wr(13'h034, 32'd1); #1 chk("R9 host on", {31'd0, irq_out}, 32'd1);
        rd(13'h1500, v); chk("R9 host word on", v, 32'd2);
        wr(13'h010, 32'd0); #1 chk("R9 global off", {31'd0, irq_out}, 32'd0);
        wr(13'h010, 32'd1); #1 chk("R9 global on", {31'd0, irq_out}, 32'd1);

        // R5 index enable
        wr(13'h02C, 32'd2); #1 chk("R5 disable", {31'd0, irq_out}, 32'd0);
        rd(13'h080, v); chk("R8 none flag", v, 32'h8000_0000);
        wr(13'h028, 32'd64); rd(13'h380, v); chk("R5 out of range", v, 32'd0);
        wr(13'h028, 32'd2); #1 chk("R5 enable", {31'd0, irq_out}, 32'd1);
        wr(13'h380, 32'h4); rd(13'h380, v); chk("R6 enable bitmap", v, 32'd0);
        #1 chk("R6 enable bitmap irq", {31'd0, irq_out}, 32'd0);

        // R7/R8 channel priority
        wr(13'h280, '1);
        wr(13'h028, 32'd5); wr(13'h028, 32'd10);
        wr(13'h404, 32'h0000_0300); wr(13'h408, 32'h0001_0000);
        rd(13'h408, v); chk("R7 map readback", v, 32'h0001_0000);
        pulse(5); pulse(10);
        rd(13'h080, v); chk("R8 lower channel wins", v, 32'd10);
        wr(13'h404, 32'h0000_0200); wr(13'h408, 32'h0002_0000);
        rd(13'h080, v); chk("R8 tie lowest index", v, 32'd5);
        wr(13'h408, 32'h0000_0000);
        rd(13'h080, v); chk("R8 channel zero", v, 32'd10);

        // R3 level re-latch
        wr(13'hD80, 32'hFFFF_FF7F);
        @(negedge clk); pins[7] = 1'b1;
        idle(5);
        wr(13'h024, 32'd7);
        rd(13'h280, v); chk("R3 level re-latch", v & 32'h80, 32'h80);
        @(negedge clk); pins[7] = 1'b0;
        idle(5);
        wr(13'h024, 32'd7);
        rd(13'h280, v); chk("R3 level idle clears", v & 32'h80, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule